// File: doc/BRIEF.md
# Asynchronous Static Memory Cycle Sequencer

This block sits between a clocked system and a single-bit-wide asynchronous static memory. A request carries a direction, an address and, for a write, one data bit. The block turns each request into a complete memory cycle. It drives an active-low chip select, an active-low write strobe, the address and the write data. On a read it captures the memory's data output.

Each timing minimum of the memory is a parameter counted in clock cycles: address setup, write pulse width, data setup, write recovery, data hold, access time from address, access time from chip select, read cycle time and write cycle time. Where two minimums bound the same interval, the longer one is applied. The block accepts one request at a time, and only while idle. It marks the end of every cycle with a one-cycle `done` pulse. A read also produces a one-cycle `rd_valid` pulse with the captured bit.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, `mem_cs_n` and `mem_we_n` are 1, `req_ready` is 1, and `done` and `rd_valid` are 0.
- R2: A request is taken only at a clock edge where `req_ready` is 1, and `req_ready` is 1 only while idle. A request presented while a cycle is in progress does not change `mem_addr` and starts no cycle.
- R3: On the edge that accepts a request, `mem_cs_n` goes to 0 and `mem_addr` takes the request address. For a write, `mem_din` takes the request data on the same edge. Address and data then stay unchanged for as long as `mem_cs_n` is 0.
- R4: For a write, `mem_we_n` falls T_AS cycles after the accepting edge.
- R5: `mem_we_n` stays 0 for max(T_WP, T_DS) cycles, and it is 0 only while `mem_cs_n` is 0.
- R6: After `mem_we_n` rises, chip select, address and data are held for at least max(T_WR, T_DH) cycles.
- R7: A write cycle ends max(T_WC, T_AS + max(T_WP,T_DS) + max(T_WR,T_DH)) cycles after the accepting edge. At that edge `mem_cs_n` returns to 1 and `done` is 1 for exactly one cycle.
- R8: During a read cycle `mem_we_n` stays 1 throughout.
- R9: A read samples `mem_dout` at the edge max(T_ACC, T_CO) cycles after the accepting edge. From that edge, `rd_data` holds the sampled bit and `rd_valid` is 1 for one cycle.
- R10: A read cycle ends max(T_RC, max(T_ACC,T_CO)) cycles after the accepting edge, with `mem_cs_n` returning to 1 and a one-cycle `done`.
- R11: A request held pending during a cycle is accepted on the edge after the one that ends the cycle. Two address changes are therefore at least one cycle time plus one clock apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | 1 | Bit to write |
| req_ready | output | 1 | Idle, a request is taken at the next edge |
| done | output | 1 | One-cycle pulse at the end of each memory cycle |
| rd_valid | output | 1 | One-cycle pulse with captured read data |
| rd_data | output | 1 | Captured read bit |
| mem_addr | output | ADDR_W | Address to the memory |
| mem_cs_n | output | 1 | Active-low chip select |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_din | output | 1 | Data to the memory |
| mem_dout | input | 1 | Data from the memory |

## Verification
All results are counted from the accepting edge, called edge 0. For a write, the strobe falls after edge T_AS and rises after edge T_AS+max(T_WP,T_DS); chip select rises and `done` appears after edge WLEN. For a read, `rd_valid` and the data appear after edge max(T_ACC,T_CO), and `done` after edge RLEN. The bench samples on the falling edge that follows each rising edge k and compares the recorded index of each event with these formulas. Its memory model returns the inverted bit until the access time has passed, so a capture one edge early reads wrong data.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_PULSE,
        PH_RECOV,
        PH_ACCESS,
        PH_TAIL
    } phase_e;

    typedef struct packed {
        logic wr;
        logic din;
    } op_t;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned min2(input int unsigned a, input int unsigned b);
        return (a < b) ? a : b;
    endfunction

    function automatic int unsigned bits_for(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/sct_cycle_timer.sv
module sct_cycle_timer #(
    parameter int unsigned CNT_W = 4,
    parameter int unsigned LIMIT = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             busy,
    output logic [CNT_W-1:0] next_cnt
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= '0;
        end else if (busy) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign next_cnt = cnt + 1'b1;

    // R7 R10
    timer_bound_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (cnt < CNT_W'(LIMIT)));

endmodule

// File: rtl/sct_sequencer.sv
module sct_sequencer
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W = 10,
    parameter int unsigned CNT_W  = 4,
    parameter int unsigned T_AS   = 1,
    parameter int unsigned WPW    = 2,
    parameter int unsigned REC    = 1,
    parameter int unsigned ACC    = 3,
    parameter int unsigned WLEN   = 5,
    parameter int unsigned RLEN   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_wdata,
    input  logic [CNT_W-1:0]  k,
    output logic              req_ready,
    output logic              start,
    output logic              busy,
    output logic              cap_stb,
    output logic              done,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_we_n,
    output logic              mem_din
);
    localparam logic [CNT_W-1:0] K_FALL  = CNT_W'(T_AS);
    localparam logic [CNT_W-1:0] K_RISE  = CNT_W'(T_AS + WPW);
    localparam logic [CNT_W-1:0] K_END   = CNT_W'(T_AS + WPW + REC);
    localparam logic [CNT_W-1:0] K_CAP   = CNT_W'(ACC);
    localparam logic [CNT_W-1:0] K_WLEN  = CNT_W'(WLEN);
    localparam logic [CNT_W-1:0] K_RLEN  = CNT_W'(RLEN);
    localparam bit               W_SHORT = (T_AS + WPW + REC) >= WLEN;
    localparam bit               R_SHORT = ACC >= RLEN;

    phase_e ph;
    op_t    op;

    assign req_ready = (ph == PH_IDLE);
    assign busy      = (ph != PH_IDLE);
    assign start     = req_ready && req_valid;
    assign cap_stb   = (ph == PH_ACCESS) && (k == K_CAP);
    assign mem_din   = op.din;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph       <= PH_IDLE;
            op       <= '0;
            mem_addr <= '0;
            mem_cs_n <= 1'b1;
            mem_we_n <= 1'b1;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (ph)
                PH_IDLE: begin
                    if (req_valid) begin
                        mem_addr <= req_addr;
                        op       <= '{wr: req_write, din: req_wdata};
                        mem_cs_n <= 1'b0;
                        ph       <= req_write ? PH_SETUP : PH_ACCESS;
                    end
                end
                PH_SETUP: begin
                    if (k == K_FALL) begin
                        mem_we_n <= 1'b0;
                        ph       <= PH_PULSE;
                    end
                end
                PH_PULSE: begin
                    if (k == K_RISE) begin
                        mem_we_n <= 1'b1;
                        ph       <= PH_RECOV;
                    end
                end
                PH_RECOV: begin
                    if (k == K_END) begin
                        if (W_SHORT) begin
                            ph       <= PH_IDLE;
                            mem_cs_n <= 1'b1;
                            done     <= 1'b1;
                        end else begin
                            ph <= PH_TAIL;
                        end
                    end
                end
                PH_ACCESS: begin
                    if (k == K_CAP) begin
                        if (R_SHORT) begin
                            ph       <= PH_IDLE;
                            mem_cs_n <= 1'b1;
                            done     <= 1'b1;
                        end else begin
                            ph <= PH_TAIL;
                        end
                    end
                end
                PH_TAIL: begin
                    if (k == (op.wr ? K_WLEN : K_RLEN)) begin
                        ph       <= PH_IDLE;
                        mem_cs_n <= 1'b1;
                        done     <= 1'b1;
                    end
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

    // R3
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!mem_cs_n && !$past(mem_cs_n)) |-> ($stable(mem_addr) && $stable(mem_din)));

    // R5
    we_in_cs_chk: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> !mem_cs_n);

    // R8
    read_we_high_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !op.wr) |-> mem_we_n);

    // R7 R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R2
    no_accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !mem_cs_n) |=> $stable(mem_addr) || mem_cs_n || $past(done));

endmodule

// File: rtl/sct_read_capture.sv
module sct_read_capture (
    input  logic clk,
    input  logic rst,
    input  logic cap_stb,
    input  logic mem_dout,
    output logic rd_valid,
    output logic rd_data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= 1'b0;
        end else begin
            rd_valid <= cap_stb;
            if (cap_stb) begin
                rd_data <= mem_dout;
            end
        end
    end

    // R9
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);

endmodule

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W = 10,
    parameter int unsigned T_AS   = 1,
    parameter int unsigned T_WP   = 2,
    parameter int unsigned T_DS   = 2,
    parameter int unsigned T_WR   = 1,
    parameter int unsigned T_DH   = 1,
    parameter int unsigned T_WC   = 5,
    parameter int unsigned T_ACC  = 3,
    parameter int unsigned T_CO   = 2,
    parameter int unsigned T_RC   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_wdata,
    output logic              req_ready,
    output logic              done,
    output logic              rd_valid,
    output logic              rd_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_we_n,
    output logic              mem_din,
    input  logic              mem_dout
);
    localparam int unsigned WPW     = max2(T_WP, T_DS);
    localparam int unsigned REC     = max2(T_WR, T_DH);
    localparam int unsigned ACC     = max2(T_ACC, T_CO);
    localparam int unsigned WLEN    = max2(T_WC, T_AS + WPW + REC);
    localparam int unsigned RLEN    = max2(T_RC, ACC);
    localparam int unsigned LONGEST = max2(WLEN, RLEN);
    localparam int unsigned CYC_MIN = min2(WLEN, RLEN);
    localparam int unsigned CNT_W   = bits_for(LONGEST + 2);

    logic [CNT_W-1:0] k;
    logic             start;
    logic             busy;
    logic             cap_stb;

    sct_cycle_timer #(
        .CNT_W (CNT_W),
        .LIMIT (LONGEST)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .busy     (busy),
        .next_cnt (k)
    );

    sct_sequencer #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W),
        .T_AS   (T_AS),
        .WPW    (WPW),
        .REC    (REC),
        .ACC    (ACC),
        .WLEN   (WLEN),
        .RLEN   (RLEN)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .k         (k),
        .req_ready (req_ready),
        .start     (start),
        .busy      (busy),
        .cap_stb   (cap_stb),
        .done      (done),
        .mem_addr  (mem_addr),
        .mem_cs_n  (mem_cs_n),
        .mem_we_n  (mem_we_n),
        .mem_din   (mem_din)
    );

    sct_read_capture u_cap (
        .clk      (clk),
        .rst      (rst),
        .cap_stb  (cap_stb),
        .mem_dout (mem_dout),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    // Pin-level run-length counters used only by the timing checks below.
    logic [CNT_W-1:0] cs_low_run;
    logic [CNT_W-1:0] we_low_run;
    logic [CNT_W-1:0] we_high_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_low_run  <= '0;
            we_low_run  <= '0;
            we_high_run <= '1;
        end else begin
            cs_low_run  <= mem_cs_n ? '0 : ((cs_low_run == '1) ? cs_low_run : cs_low_run + 1'b1);
            we_low_run  <= mem_we_n ? '0 : ((we_low_run == '1) ? we_low_run : we_low_run + 1'b1);
            we_high_run <= !mem_we_n ? '0 : ((we_high_run == '1) ? we_high_run : we_high_run + 1'b1);
        end
    end

    // R4
    addr_setup_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_we_n) |-> (cs_low_run >= CNT_W'(T_AS)));

    // R5
    wp_width_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> (we_low_run >= CNT_W'(WPW)));

    // R6
    recovery_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_cs_n) |-> (we_high_run >= CNT_W'(REC)));

    // R11
    cycle_len_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_cs_n) |-> (cs_low_run >= CNT_W'(CYC_MIN)));

endmodule

// File: tb/sram_cycle_ctrl_tb.sv
module sram_cycle_ctrl_tb;
    localparam int AW    = 10;
    localparam int T_AS  = 2;
    localparam int T_WP  = 3;
    localparam int T_DS  = 4;
    localparam int T_WR  = 1;
    localparam int T_DH  = 2;
    localparam int T_WC  = 8;
    localparam int T_ACC = 3;
    localparam int T_CO  = 5;
    localparam int T_RC  = 7;
    localparam int WPW   = (T_WP > T_DS) ? T_WP : T_DS;
    localparam int REC   = (T_WR > T_DH) ? T_WR : T_DH;
    localparam int ACC   = (T_ACC > T_CO) ? T_ACC : T_CO;
    localparam int WSUM  = T_AS + WPW + REC;
    localparam int WLEN  = (T_WC > WSUM) ? T_WC : WSUM;
    localparam int RLEN  = (T_RC > ACC) ? T_RC : ACC;

    // vector: [12]=write, [11]=write data, [10]=expected read bit, [9:0]=address
    localparam int NV = 9;
    localparam logic [12:0] VEC [NV] = '{
        {1'b1, 1'b1, 1'b0, 10'h000},
        {1'b1, 1'b0, 1'b0, 10'h3FF},
        {1'b1, 1'b1, 1'b0, 10'h155},
        {1'b0, 1'b0, 1'b1, 10'h000},
        {1'b0, 1'b0, 1'b0, 10'h3FF},
        {1'b0, 1'b0, 1'b1, 10'h155},
        {1'b1, 1'b0, 1'b0, 10'h155},
        {1'b0, 1'b0, 1'b0, 10'h155},
        {1'b0, 1'b0, 1'b0, 10'h2AA}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          req_wdata = 1'b0;
    logic          req_ready, done, rd_valid, rd_data;
    logic [AW-1:0] mem_addr;
    logic          mem_cs_n, mem_we_n, mem_din, mem_dout;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    sram_cycle_ctrl #(
        .ADDR_W (AW), .T_AS (T_AS), .T_WP (T_WP), .T_DS (T_DS), .T_WR (T_WR),
        .T_DH (T_DH), .T_WC (T_WC), .T_ACC (T_ACC), .T_CO (T_CO), .T_RC (T_RC)
    ) u_dut (
        .clk (clk), .rst (rst), .req_valid (req_valid), .req_write (req_write),
        .req_addr (req_addr), .req_wdata (req_wdata), .req_ready (req_ready),
        .done (done), .rd_valid (rd_valid), .rd_data (rd_data),
        .mem_addr (mem_addr), .mem_cs_n (mem_cs_n), .mem_we_n (mem_we_n),
        .mem_din (mem_din), .mem_dout (mem_dout)
    );

    // Memory model: gives the inverted bit until the access time has elapsed.
    logic mem_model [2**AW];
    int   tb_run = 0;

    always @(posedge clk) begin
        tb_run <= mem_cs_n ? 0 : tb_run + 1;
        if (!mem_cs_n && !mem_we_n) mem_model[mem_addr] <= mem_din;
    end

    assign mem_dout = mem_cs_n ? 1'b0 :
                      (!mem_we_n ? mem_din :
                      ((tb_run + 1 >= ACC) ? mem_model[mem_addr] : ~mem_model[mem_addr]));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_op(input logic wr, input logic [AW-1:0] a, input logic d, input logic ex);
        int fall_k = -1;
        int rise_k = -1;
        int done_k = -1;
        int cs_k   = -1;
        int rv_k   = -1;
        int ndone  = 0;
        int bad_hold = 0;
        logic rv_bit = 1'b0;
        int len = wr ? WLEN : RLEN;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        chk(req_ready == 1'b1, "R2 ready before accept", int'(req_ready), 1);
        @(negedge clk);
        req_valid = 1'b0;
        chk(mem_cs_n == 1'b0, "R3 cs low after accept", int'(mem_cs_n), 0);
        chk(mem_addr == a, "R3 address driven at accept", int'(mem_addr), int'(a));
        for (int k = 0; k <= len + 2; k++) begin
            if (k > 0) @(negedge clk);
            if (!mem_we_n && fall_k < 0) fall_k = k;
            if (mem_we_n && fall_k >= 0 && rise_k < 0) rise_k = k;
            if (mem_cs_n && cs_k < 0) cs_k = k;
            if (done) begin ndone++; if (done_k < 0) done_k = k; end
            if (rd_valid && rv_k < 0) begin rv_k = k; rv_bit = rd_data; end
            if (!mem_cs_n && (mem_addr != a || (wr && mem_din != d))) bad_hold++;
        end
        chk(bad_hold == 0, "R3 address/data held while selected", bad_hold, 0);
        chk(ndone == 1, "R7 R10 single done pulse", ndone, 1);
        if (wr) begin
            chk(fall_k == T_AS, "R4 strobe fall index", fall_k, T_AS);
            chk(rise_k - fall_k == WPW, "R5 strobe low width", rise_k - fall_k, WPW);
            chk(cs_k - rise_k >= REC, "R6 hold after strobe rise", cs_k - rise_k, REC);
            chk(done_k == WLEN, "R7 write cycle end", done_k, WLEN);
            chk(cs_k == WLEN, "R7 select release on write", cs_k, WLEN);
        end else begin
            chk(fall_k == -1, "R8 strobe stays high on read", fall_k, -1);
            chk(rv_k == ACC, "R9 read valid index", rv_k, ACC);
            chk(rv_bit == ex, "R9 read data", int'(rv_bit), int'(ex));
            chk(done_k == RLEN, "R10 read cycle end", done_k, RLEN);
            chk(cs_k == RLEN, "R10 select release on read", cs_k, RLEN);
        end
    endtask

    initial begin
        for (int i = 0; i < 2**AW; i++) mem_model[i] = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk(mem_cs_n == 1'b1, "R1 cs_n in reset", int'(mem_cs_n), 1);
        chk(mem_we_n == 1'b1, "R1 we_n in reset", int'(mem_we_n), 1);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
        chk(done == 1'b0, "R1 done after reset", int'(done), 0);
        chk(rd_valid == 1'b0, "R1 rd_valid after reset", int'(rd_valid), 0);
        chk(mem_cs_n == 1'b1, "R1 cs_n after reset", int'(mem_cs_n), 1);

        for (int v = 0; v < NV; v++) begin
            run_op(VEC[v][12], VEC[v][AW-1:0], VEC[v][11], VEC[v][10]);
        end

        // R2: request arriving while busy is ignored
        begin
            int bad = 0;
            int rdy = 0;
            @(negedge clk);
            req_valid = 1'b1; req_write = 1'b1; req_addr = 10'h0AA; req_wdata = 1'b1;
            @(negedge clk);
            req_write = 1'b0; req_addr = 10'h2C3;
            for (int k = 1; k < WLEN; k++) begin
                if (k == WLEN - 1) req_valid = 1'b0;
                if (!mem_cs_n && mem_addr != 10'h0AA) bad++;
                if (req_ready) rdy++;
                @(negedge clk);
            end
            chk(bad == 0, "R2 address kept while busy", bad, 0);
            chk(rdy == 0, "R2 ready low while busy", rdy, 0);
            repeat (3) @(negedge clk);
            chk(mem_cs_n == 1'b1, "R2 late request not started", int'(mem_cs_n), 1);
            chk(mem_addr == 10'h0AA, "R2 address unchanged after ignore", int'(mem_addr), 'h0AA);
        end

        // R11: request pending across a cycle is taken on the edge after done
        begin
            int chg_k = -1;
            int rv_k = -1;
            logic rv_bit = 1'b0;
            @(negedge clk);
            req_valid = 1'b1; req_write = 1'b1; req_addr = 10'h0F0; req_wdata = 1'b1;
            @(negedge clk);
            req_write = 1'b0; req_addr = 10'h000;
            for (int k = 0; k <= WLEN + RLEN + 3; k++) begin
                if (k > 0) @(negedge clk);
                if (mem_addr == 10'h000 && chg_k < 0) begin
                    chg_k = k;
                    req_valid = 1'b0;
                end
                if (rd_valid && rv_k < 0) begin rv_k = k; rv_bit = rd_data; end
            end
            chk(chg_k == WLEN + 1, "R11 next address change index", chg_k, WLEN + 1);
            chk(rv_k == WLEN + 1 + ACC, "R11 R9 back-to-back read valid", rv_k, WLEN + 1 + ACC);
            chk(rv_bit == 1'b1, "R11 R9 back-to-back read data", int'(rv_bit), 1);
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule